// File: doc/BRIEF.md
# Mode-Selected Four-Bit Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit with two operands `a` and `b`. A four-bit select `sel` chooses one of sixteen functions. A single `mode` bit decides whether that code is read as an arithmetic or as a bitwise logic function. In arithmetic mode the unit adds two addends formed from the operands, plus the active-high carry input `cin`, and it reports the carry leaving the top bit. In logic mode the carry input has no effect and the carry output is held low.

Two more outputs let a wider datapath chain several units through an external lookahead carry generator: a group propagate and a group generate, both derived from the per-bit addend terms. A compare flag is high whenever every result bit is one. With the subtract code and `cin` low, that makes it an equality detector for the operands.

The operand width is a parameter, with a default of four bits. A second parameter selects either a rippled carry chain or a flattened lookahead carry network. Both variants give the same results at the ports.

Top module: `mode_alu`

## Requirements
- R1: With `mode`=1, `f` is a bitwise function of `a` and `b` set by `sel`: 0000 ~A, 0001 ~(A|B), 0010 ~A&B, 0011 all zeros, 0100 ~(A&B), 0101 ~B, 0110 A^B, 0111 A&~B, 1000 ~A|B, 1001 ~(A^B), 1010 B, 1011 A&B, 1100 all ones, 1101 A|~B, 1110 A|B, 1111 A.
- R2: With `mode`=1, changing `cin` changes none of the outputs.
- R3: With `mode`=0, `f` is the low four bits of X + Y + `cin`. X is picked by `sel[1:0]` (00 A, 01 A|B, 10 A|~B, 11 all ones). Y is picked by `sel[3:2]` (00 zero, 01 A&~B, 10 A&B, 11 A). This makes 0000 A+cin, 0001 (A|B)+cin, 0110 A-B-1+cin, 1001 A+B+cin, 1100 A+A+cin and 1111 A-1+cin.
- R4: With `mode`=0, `cout` is bit 4 of the five-bit sum X + Y + `cin`.
- R5: With `mode`=1, `cout` is 0.
- R6: `a_eq_b` is 1 exactly when all four bits of `f` are 1, in either mode.
- R7: With `mode`=0, `sel`=0110 and `cin`=0, `a_eq_b` is 1 exactly when `a` equals `b`.
- R8: `grp_p` is 1 exactly when X is all ones.
- R9: `grp_g` is 1 exactly when X + Y, without `cin`, is 16 or more.
- R10: `grp_p` and `grp_g` depend only on `a`, `b` and `sel`, never on `mode` or `cin`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 4 | First operand |
| b | input | 4 | Second operand |
| sel | input | 4 | Function select code |
| mode | input | 1 | 1 selects logic functions, 0 selects arithmetic |
| cin | input | 1 | Active-high carry into bit 0 |
| f | output | 4 | Function result |
| cout | output | 1 | Carry out of the top bit (0 in logic mode) |
| a_eq_b | output | 1 | High when every bit of `f` is one |
| grp_p | output | 1 | Group propagate for external lookahead |
| grp_g | output | 1 | Group generate for external lookahead |

## Verification
There is no stored state, so every fault in the addend selection, the carry network or the result stage appears at the ports on the same input vector that exposes it. A wrong addend term for one select code corrupts `f`, `cout` and the group terms for that code only. A broken carry link shows up only on the vectors whose carry travels through that bit, typically as a wrong `cout` or an upper `f` bit that is off by one. Sweeping every combination of operands, select, mode and carry reaches each of these vectors, and the random and directed vectors add extra coverage of the carry extremes.

// File: rtl/mode_alu_pkg.sv
package mode_alu_pkg;
   typedef enum logic {
      CARRY_RIPPLE    = 1'b0,
      CARRY_LOOKAHEAD = 1'b1
   } carry_style_e;

   localparam int unsigned SEL_BITS = 4;
endpackage

// File: rtl/alu_operand_terms.sv
module alu_operand_terms #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0]                      a,
   input  logic [WIDTH-1:0]                      b,
   input  logic [mode_alu_pkg::SEL_BITS-1:0]     sel,
   output logic [WIDTH-1:0]                      addend_x,
   output logic [WIDTH-1:0]                      addend_y
);
   if (WIDTH < 1) begin : g_width_bad
      $error("alu_operand_terms: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
         addend_x[i] = a[i] | (b[i] & sel[0]) | (~b[i] & sel[1]);
         addend_y[i] = (a[i] & b[i] & sel[3]) | (a[i] & ~b[i] & sel[2]);
      end
   end
endmodule

// File: rtl/alu_carry_net.sv
module alu_carry_net #(
   parameter int unsigned               WIDTH = 4,
   parameter mode_alu_pkg::carry_style_e STYLE = mode_alu_pkg::CARRY_LOOKAHEAD
) (
   input  logic [WIDTH-1:0] addend_x,
   input  logic [WIDTH-1:0] addend_y,
   input  logic             cin,
   output logic [WIDTH:0]   carry,
   output logic             grp_p,
   output logic             grp_g
);
   if (WIDTH < 1) begin : g_width_bad
      $error("alu_carry_net: WIDTH must be at least 1");
   end

   // Group terms: propagate is the OR-form term (addend_y lies inside addend_x)
   always_comb begin
      logic run_g;
      logic run_p;
      run_g = 1'b0;
      run_p = 1'b1;
      for (int i = 0; i < WIDTH; i++) begin
         run_g = addend_y[i] | (addend_x[i] & run_g);
         run_p = run_p & addend_x[i];
      end
      grp_g = run_g;
      grp_p = run_p;
   end

   if (STYLE == mode_alu_pkg::CARRY_RIPPLE) begin : g_ripple
      always_comb begin
         logic c;
         c = cin;
         for (int i = 0; i < WIDTH; i++) begin
            carry[i] = c;
            c = addend_y[i] | (addend_x[i] & c);
         end
         carry[WIDTH] = c;
      end
   end else begin : g_lookahead
      always_comb begin
         logic sub_g;
         logic sub_p;
         carry[0] = cin;
         for (int i = 0; i < WIDTH; i++) begin
            sub_g = 1'b0;
            sub_p = 1'b1;
            for (int j = 0; j <= i; j++) begin
               sub_g = addend_y[j] | (addend_x[j] & sub_g);
               sub_p = sub_p & addend_x[j];
            end
            carry[i+1] = sub_g | (sub_p & cin);
         end
      end
   end

   always_comb begin
      // R3
      addend_nest_chk: assert ((addend_y & ~addend_x) == '0)
         else $error("second addend term outside first addend term");
      // R9
      group_carry_chk: assert (carry[WIDTH] == (grp_g | (grp_p & cin)))
         else $error("top carry disagrees with group terms");
   end
endmodule

// File: rtl/alu_result_stage.sv
module alu_result_stage #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] addend_x,
   input  logic [WIDTH-1:0] addend_y,
   input  logic [WIDTH:0]   carry,
   input  logic             mode,
   output logic [WIDTH-1:0] f,
   output logic             cout,
   output logic             a_eq_b
);
   logic [WIDTH-1:0] half_sum;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
         half_sum[i] = addend_x[i] ^ addend_y[i];
         f[i]        = mode ? ~half_sum[i] : (half_sum[i] ^ carry[i]);
      end
   end

   always_comb begin
      cout   = mode ? 1'b0 : carry[WIDTH];
      a_eq_b = &f;
   end
endmodule

// File: rtl/mode_alu.sv
module mode_alu #(
   parameter int unsigned               WIDTH = 4,
   parameter mode_alu_pkg::carry_style_e STYLE = mode_alu_pkg::CARRY_LOOKAHEAD
) (
   input  logic [WIDTH-1:0]                  a,
   input  logic [WIDTH-1:0]                  b,
   input  logic [mode_alu_pkg::SEL_BITS-1:0] sel,
   input  logic                              mode,
   input  logic                              cin,
   output logic [WIDTH-1:0]                  f,
   output logic                              cout,
   output logic                              a_eq_b,
   output logic                              grp_p,
   output logic                              grp_g
);
   localparam int unsigned SUM_W = WIDTH + 1;

   if (WIDTH < 1) begin : g_width_bad
      $error("mode_alu: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] addend_x;
   logic [WIDTH-1:0] addend_y;
   logic [WIDTH:0]   carry;

   alu_operand_terms #(.WIDTH(WIDTH)) u_terms (
      .a        (a),
      .b        (b),
      .sel      (sel),
      .addend_x (addend_x),
      .addend_y (addend_y)
   );

   alu_carry_net #(.WIDTH(WIDTH), .STYLE(STYLE)) u_carry (
      .addend_x (addend_x),
      .addend_y (addend_y),
      .cin      (cin),
      .carry    (carry),
      .grp_p    (grp_p),
      .grp_g    (grp_g)
   );

   alu_result_stage #(.WIDTH(WIDTH)) u_result (
      .addend_x (addend_x),
      .addend_y (addend_y),
      .carry    (carry),
      .mode     (mode),
      .f        (f),
      .cout     (cout),
      .a_eq_b   (a_eq_b)
   );

   always_comb begin
      logic [SUM_W-1:0] add_ref;
      add_ref = {1'b0, a} + {1'b0, b} + SUM_W'(cin);
      // R5
      logic_cout_low_chk: assert (!(mode && cout))
         else $error("carry out high in logic mode");
      // R4
      if (!mode && sel == 4'b1001) begin
         plain_add_chk: assert ({cout, f} == add_ref)
            else $error("A+B+cin mismatch");
      end
      // R7
      if (!mode && sel == 4'b0110 && !cin) begin
         equal_detect_chk: assert (a_eq_b == (a == b))
            else $error("equality flag wrong in subtract code");
      end
      // R9
      if (!mode && grp_g) begin
         gen_forces_carry_chk: assert (cout)
            else $error("group generate without carry out");
      end
      // R8
      if (!mode && grp_p && cin) begin
         prop_passes_carry_chk: assert (cout)
            else $error("group propagate did not pass carry in");
      end
   end
endmodule

// File: tb/mode_alu_tb.sv
module mode_alu_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] a = '0;
   logic [3:0] b = '0;
   logic [3:0] sel = '0;
   logic       mode = 1'b0;
   logic       cin = 1'b0;
   logic [3:0] f;
   logic       cout, a_eq_b, grp_p, grp_g;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   mode_alu u_dut (
      .a(a), .b(b), .sel(sel), .mode(mode), .cin(cin),
      .f(f), .cout(cout), .a_eq_b(a_eq_b), .grp_p(grp_p), .grp_g(grp_g)
   );

   function automatic logic [3:0] first_addend(logic [3:0] x, logic [3:0] y, logic [1:0] s);
      case (s)
         2'b00:   return x;
         2'b01:   return x | y;
         2'b10:   return x | ~y;
         default: return 4'hF;
      endcase
   endfunction

   function automatic logic [3:0] second_addend(logic [3:0] x, logic [3:0] y, logic [1:0] s);
      case (s)
         2'b00:   return 4'h0;
         2'b01:   return x & ~y;
         2'b10:   return x & y;
         default: return x;
      endcase
   endfunction

   function automatic logic [3:0] logic_ref(logic [3:0] x, logic [3:0] y, logic [3:0] s);
      case (s)
         4'h0: return ~x;
         4'h1: return ~(x | y);
         4'h2: return ~x & y;
         4'h3: return 4'h0;
         4'h4: return ~(x & y);
         4'h5: return ~y;
         4'h6: return x ^ y;
         4'h7: return x & ~y;
         4'h8: return ~x | y;
         4'h9: return ~(x ^ y);
         4'hA: return y;
         4'hB: return x & y;
         4'hC: return 4'hF;
         4'hD: return x | ~y;
         4'hE: return x | y;
         default: return x;
      endcase
   endfunction

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s a=%h b=%h sel=%b mode=%b cin=%b actual=%0h expected=%0h",
                  req, a, b, sel, mode, cin, act, exp);
      end
   endtask

   task automatic apply(logic [3:0] ta, logic [3:0] tb, logic [3:0] ts, logic tm, logic tc);
      logic [3:0] x, y, ef;
      logic [4:0] sum, xy;
      @(posedge clk);
      a = ta; b = tb; sel = ts; mode = tm; cin = tc;
      @(negedge clk);
      x   = first_addend(ta, tb, ts[1:0]);
      y   = second_addend(ta, tb, ts[3:2]);
      sum = {1'b0, x} + {1'b0, y} + {4'b0, tc};
      xy  = {1'b0, x} + {1'b0, y};
      if (tm) begin
         ef = logic_ref(ta, tb, ts);
         check("R1", int'(f), int'(ef));
         check("R5", int'(cout), 0);
      end else begin
         ef = sum[3:0];
         check("R3", int'(f), int'(ef));
         check("R4", int'(cout), int'(sum[4]));
      end
      check("R6", int'(a_eq_b), int'(ef == 4'hF));
      check("R8", int'(grp_p), int'(x == 4'hF));
      check("R9", int'(grp_g), int'(xy[4]));
   endtask

   // R2 and R10: toggle cin and mode, outputs that must not move are compared
   task automatic invariance(logic [3:0] ta, logic [3:0] tb, logic [3:0] ts);
      logic [3:0] f0;
      logic c0, e0, p0, g0;
      apply(ta, tb, ts, 1'b1, 1'b0);
      f0 = f; c0 = cout; e0 = a_eq_b; p0 = grp_p; g0 = grp_g;
      apply(ta, tb, ts, 1'b1, 1'b1);
      check("R2", int'({f, cout, a_eq_b}), int'({f0, c0, e0}));
      check("R10", int'({grp_p, grp_g}), int'({p0, g0}));
      apply(ta, tb, ts, 1'b0, 1'b1);
      check("R10", int'({grp_p, grp_g}), int'({p0, g0}));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd1234);
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // quiescent state with all inputs at zero: A+0, f=0
      @(negedge clk);
      check("R3", int'(f), 0);
      check("R4", int'(cout), 0);
      check("R6", int'(a_eq_b), 0);

      // directed corners
      apply(4'hF, 4'h1, 4'b1001, 1'b0, 1'b0); // R4 carry out
      apply(4'hF, 4'hF, 4'b1001, 1'b0, 1'b1); // R4 max sum
      apply(4'h5, 4'h5, 4'b0110, 1'b0, 1'b0); // R7 equal
      check("R7", int'(a_eq_b), 1);
      apply(4'h5, 4'h4, 4'b0110, 1'b0, 1'b0); // R7 unequal
      check("R7", int'(a_eq_b), 0);
      apply(4'h3, 4'h3, 4'b0110, 1'b0, 1'b1); // true difference zero
      check("R3", int'(f), 0);
      apply(4'h0, 4'h0, 4'b1111, 1'b0, 1'b0); // 0-1 wraps, no carry
      apply(4'h8, 4'h0, 4'b1100, 1'b0, 1'b0); // A+A overflow
      apply(4'h0, 4'h7, 4'b0011, 1'b0, 1'b1); // propagate passes cin
      apply(4'hA, 4'h5, 4'b1100, 1'b1, 1'b1); // ones constant
      invariance(4'h6, 4'h9, 4'b0110);
      invariance(4'hF, 4'h0, 4'b0011);

      // constrained random
      for (int k = 0; k < 3000; k++) begin
         logic [13:0] v;
         v = 14'($urandom());
         apply(v[3:0], v[7:4], v[11:8], v[12], v[13]);
         if (k % 500 == 0) invariance(v[3:0], v[7:4], v[11:8]);
      end

      // exhaustive sweep
      for (int v = 0; v < 16384; v++) begin
         logic [13:0] w;
         w = 14'(v);
         apply(w[3:0], w[7:4], w[11:8], w[12], w[13]);
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule